// File: doc/BRIEF.md
# Register Rename Map with Entry-Valid Bits

This block keeps, for each architectural register, whether the register currently has a rename buffer assigned and, if so, which buffer. Each cycle the issue stage presents a group of instructions, oldest in lane 0. The block answers every source operand of the group with a hit flag and a buffer index. On a miss the caller reads the architectural register file instead. The same group may record new destination mappings, which the table holds from the next cycle on.

Completion logic returns reclaimed buffers on several reclaim ports. A reclaim clears an entry only if the entry still points at the returned buffer, so a mapping that a later rename has replaced stays in place. A flush input drops every mapping at once. A source that names a destination written by an older instruction of the same group gets that instruction's new buffer index directly, in the same cycle, without going through the table.

Top module: `rmt_top`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup reports a miss.
- R2: Lane 0 sources return hit=1 and the stored index for a valid entry, and hit=0 with index 0 for an invalid entry.
- R3: A destination write sets the entry valid with the given buffer index, visible to lookups from the next cycle, and replaces any older mapping.
- R4: When several lanes of one group write the same register, the highest-numbered (youngest) lane's index is stored.
- R5: A reclaim whose buffer index equals the stored index of a valid entry clears that entry.
- R6: A reclaim whose buffer index differs from the stored index leaves the entry unchanged.
- R7: A source of lane i that names a destination of an enabled lane j<i returns hit=1 and the buffer of the youngest such lane, in the same cycle.
- R8: A source of lane i ignores the destinations of lane i itself and of younger lanes.
- R9: A write and a matching reclaim to the same register in one cycle leave the new mapping valid.
- R10: Flush invalidates every entry in one cycle, and destination writes in the flush cycle are discarded.
- R11: Reclaim ports act independently, so two ports can clear two entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all mappings |
| src_reg | input | GRP*NSRC*AW | Source register numbers, per lane and operand |
| src_hit | output | GRP*NSRC | Source is renamed |
| src_buf | output | GRP*NSRC*BW | Rename buffer index of the source |
| dst_en | input | GRP | Lane writes a destination mapping |
| dst_reg | input | GRP*AW | Destination register per lane |
| dst_buf | input | GRP*BW | Newly assigned buffer per lane |
| rcl_en | input | NRCL | Reclaim port active |
| rcl_reg | input | NRCL*AW | Register whose buffer is returned |
| rcl_buf | input | NRCL*BW | Returned buffer index |

## Verification
A reclaim and a fresh rename of the same register can arrive in one cycle. The bench maps a register, then presents a reclaim of that exact buffer together with a new destination write to the same register. It judges the outcome by a lookup in the following cycle, which must still hit with the new index. Same-group bypass and the youngest-writer rule are also exercised together, by a group in which two lanes write one register while later lanes read it.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    localparam int unsigned DEF_NUM_ARCH = 32;
    localparam int unsigned DEF_NUM_BUF  = 128;
    localparam int unsigned DEF_GRP      = 4;
    localparam int unsigned DEF_NSRC     = 2;
    localparam int unsigned DEF_NRCL     = 4;

    // outcome of comparing one stored entry against a reclaim request
    typedef enum logic [1:0] {
        RCL_IDLE  = 2'd0,
        RCL_STALE = 2'd1,
        RCL_CLEAR = 2'd2
    } rcl_kind_e;

    function automatic rcl_kind_e rcl_classify(input logic en, input logic vld,
                                               input logic idx_eq);
        if (!en)
            return RCL_IDLE;
        else if (vld && idx_eq)
            return RCL_CLEAR;
        else
            return RCL_STALE;
    endfunction
endpackage

// File: rtl/rmt_table.sv
module rmt_table
    import rmt_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
    parameter int unsigned NUM_BUF  = DEF_NUM_BUF,
    parameter int unsigned GRP      = DEF_GRP,
    parameter int unsigned NRCL     = DEF_NRCL,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned BW      = $clog2(NUM_BUF)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic [GRP-1:0]                dst_en,
    input  logic [GRP-1:0][AW-1:0]        dst_reg,
    input  logic [GRP-1:0][BW-1:0]        dst_buf,
    input  logic [NRCL-1:0]               rcl_en,
    input  logic [NRCL-1:0][AW-1:0]       rcl_reg,
    input  logic [NRCL-1:0][BW-1:0]       rcl_buf,
    output logic [NUM_ARCH-1:0]           ent_vld,
    output logic [NUM_ARCH-1:0][BW-1:0]   ent_idx
);
    logic [NUM_ARCH-1:0]         vld_nx;
    logic [NUM_ARCH-1:0][BW-1:0] idx_nx;

    always_comb begin
        vld_nx = ent_vld;
        idx_nx = ent_idx;
        // reclaims judged against the stored state of this cycle
        for (int k = 0; k < NRCL; k++) begin
            if (rcl_classify(rcl_en[k], ent_vld[rcl_reg[k]],
                             ent_idx[rcl_reg[k]] == rcl_buf[k]) == RCL_CLEAR)
                vld_nx[rcl_reg[k]] = 1'b0;
        end
        // new mappings override reclaims; later lanes override earlier lanes
        for (int g = 0; g < GRP; g++) begin
            if (dst_en[g]) begin
                vld_nx[dst_reg[g]] = 1'b1;
                idx_nx[dst_reg[g]] = dst_buf[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
            ent_idx <= '0;
        end else if (flush) begin
            ent_vld <= '0;
        end else begin
            ent_vld <= vld_nx;
            ent_idx <= idx_nx;
        end
    end
endmodule

// File: rtl/rmt_lookup.sv
module rmt_lookup
    import rmt_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
    parameter int unsigned NUM_BUF  = DEF_NUM_BUF,
    parameter int unsigned GRP      = DEF_GRP,
    parameter int unsigned NSRC     = DEF_NSRC,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned BW      = $clog2(NUM_BUF)
) (
    input  logic [NUM_ARCH-1:0]                  ent_vld,
    input  logic [NUM_ARCH-1:0][BW-1:0]          ent_idx,
    input  logic [GRP-1:0]                       dst_en,
    input  logic [GRP-1:0][AW-1:0]               dst_reg,
    input  logic [GRP-1:0][BW-1:0]               dst_buf,
    input  logic [GRP-1:0][NSRC-1:0][AW-1:0]     src_reg,
    output logic [GRP-1:0][NSRC-1:0]             src_hit,
    output logic [GRP-1:0][NSRC-1:0][BW-1:0]     src_buf
);
    for (genvar i = 0; i < GRP; i++) begin : g_lane
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            always_comb begin
                src_hit[i][s] = ent_vld[src_reg[i][s]];
                src_buf[i][s] = ent_vld[src_reg[i][s]] ? ent_idx[src_reg[i][s]] : '0;
                // older lanes only; the youngest older writer is applied last
                for (int j = 0; j < i; j++) begin
                    if (dst_en[j] && dst_reg[j] == src_reg[i][s]) begin
                        src_hit[i][s] = 1'b1;
                        src_buf[i][s] = dst_buf[j];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rmt_top.sv
module rmt_top
    import rmt_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
    parameter int unsigned NUM_BUF  = DEF_NUM_BUF,
    parameter int unsigned GRP      = DEF_GRP,
    parameter int unsigned NSRC     = DEF_NSRC,
    parameter int unsigned NRCL     = DEF_NRCL,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned BW      = $clog2(NUM_BUF)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 flush,
    input  logic [GRP-1:0][NSRC-1:0][AW-1:0]     src_reg,
    output logic [GRP-1:0][NSRC-1:0]             src_hit,
    output logic [GRP-1:0][NSRC-1:0][BW-1:0]     src_buf,
    input  logic [GRP-1:0]                       dst_en,
    input  logic [GRP-1:0][AW-1:0]               dst_reg,
    input  logic [GRP-1:0][BW-1:0]               dst_buf,
    input  logic [NRCL-1:0]                      rcl_en,
    input  logic [NRCL-1:0][AW-1:0]              rcl_reg,
    input  logic [NRCL-1:0][BW-1:0]              rcl_buf
);
    logic [NUM_ARCH-1:0]         tbl_vld;
    logic [NUM_ARCH-1:0][BW-1:0] tbl_idx;

    rmt_table #(
        .NUM_ARCH(NUM_ARCH), .NUM_BUF(NUM_BUF), .GRP(GRP), .NRCL(NRCL)
    ) u_table (
        .clk(clk), .rst(rst), .flush(flush),
        .dst_en(dst_en), .dst_reg(dst_reg), .dst_buf(dst_buf),
        .rcl_en(rcl_en), .rcl_reg(rcl_reg), .rcl_buf(rcl_buf),
        .ent_vld(tbl_vld), .ent_idx(tbl_idx)
    );

    rmt_lookup #(
        .NUM_ARCH(NUM_ARCH), .NUM_BUF(NUM_BUF), .GRP(GRP), .NSRC(NSRC)
    ) u_lookup (
        .ent_vld(tbl_vld), .ent_idx(tbl_idx),
        .dst_en(dst_en), .dst_reg(dst_reg), .dst_buf(dst_buf),
        .src_reg(src_reg), .src_hit(src_hit), .src_buf(src_buf)
    );
endmodule

// File: rtl/rmt_chk.sv
module rmt_chk #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_BUF  = 128,
    parameter int unsigned GRP      = 4,
    parameter int unsigned NSRC     = 2,
    parameter int unsigned NRCL     = 4,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned BW      = $clog2(NUM_BUF)
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              flush,
    input logic [GRP-1:0][NSRC-1:0][AW-1:0]  src_reg,
    input logic [GRP-1:0][NSRC-1:0]          src_hit,
    input logic [GRP-1:0][NSRC-1:0][BW-1:0]  src_buf,
    input logic [GRP-1:0]                    dst_en,
    input logic [GRP-1:0][AW-1:0]            dst_reg,
    input logic [GRP-1:0][BW-1:0]            dst_buf,
    input logic [NRCL-1:0]                   rcl_en,
    input logic [NRCL-1:0][AW-1:0]           rcl_reg,
    input logic [NRCL-1:0][BW-1:0]           rcl_buf,
    input logic [NUM_ARCH-1:0]               tbl_vld,
    input logic [NUM_ARCH-1:0][BW-1:0]       tbl_idx
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (tbl_vld == '0));

    a_r2_lane0_reads_table: assert property (@(posedge clk) disable iff (rst)
        (src_hit[0][0] == tbl_vld[src_reg[0][0]]) &&
        (!src_hit[0][0] || src_buf[0][0] == tbl_idx[src_reg[0][0]]));

    a_r4_youngest_lane_stored: assert property (@(posedge clk) disable iff (rst)
        (!flush && dst_en[GRP-1]) |=>
        (tbl_vld[$past(dst_reg[GRP-1])] && tbl_idx[$past(dst_reg[GRP-1])] == $past(dst_buf[GRP-1])));

    a_r5_matching_reclaim_clears: assert property (@(posedge clk) disable iff (rst)
        (!flush && dst_en == '0 && rcl_en[0] && tbl_vld[rcl_reg[0]] &&
         tbl_idx[rcl_reg[0]] == rcl_buf[0]) |=> !tbl_vld[$past(rcl_reg[0])]);

    a_r6_stale_reclaim_kept: assert property (@(posedge clk) disable iff (rst)
        (!flush && dst_en == '0 && rcl_en == 1 && tbl_vld[rcl_reg[0]] &&
         tbl_idx[rcl_reg[0]] != rcl_buf[0]) |=>
        (tbl_vld[$past(rcl_reg[0])] && tbl_idx[$past(rcl_reg[0])] == $past(tbl_idx[rcl_reg[0]])));

    a_r7_bypass_lane1: assert property (@(posedge clk) disable iff (rst)
        (dst_en[0] && dst_reg[0] == src_reg[1][0]) |->
        (src_hit[1][0] && src_buf[1][0] == dst_buf[0]));

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tbl_vld == '0));
endmodule

bind rmt_top rmt_chk #(
    .NUM_ARCH(NUM_ARCH), .NUM_BUF(NUM_BUF), .GRP(GRP), .NSRC(NSRC), .NRCL(NRCL)
) u_chk (.*);

// File: tb/rmt_top_test.sv
module rmt_top_test;
    localparam int NA = 32, NB = 128, G = 4, S = 2, NR = 4;
    localparam int AW = $clog2(NA), BW = $clog2(NB);

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic [G-1:0][S-1:0][AW-1:0] src_reg;
    logic [G-1:0][S-1:0]         src_hit;
    logic [G-1:0][S-1:0][BW-1:0] src_buf;
    logic [G-1:0]                dst_en;
    logic [G-1:0][AW-1:0]        dst_reg;
    logic [G-1:0][BW-1:0]        dst_buf;
    logic [NR-1:0]               rcl_en;
    logic [NR-1:0][AW-1:0]       rcl_reg;
    logic [NR-1:0][BW-1:0]       rcl_buf;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rmt_top uut (.*);

    typedef struct packed {
        logic         wr;
        logic [4:0]   wr_r;
        logic [6:0]   wr_b;
        logic         rc;
        logic [4:0]   rc_r;
        logic [6:0]   rc_b;
        logic [4:0]   lk_r;
        logic         e_hit;
        logic [6:0]   e_buf;
        logic [3:0]   req;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 5'd5,  7'd10,  1'b0, 5'd0,  7'd0,  5'd5,  1'b1, 7'd10,  4'd3}, // R3 first map
        '{1'b1, 5'd5,  7'd20,  1'b0, 5'd0,  7'd0,  5'd5,  1'b1, 7'd20,  4'd3}, // R3 overwrite
        '{1'b0, 5'd0,  7'd0,   1'b1, 5'd5,  7'd10, 5'd5,  1'b1, 7'd20,  4'd6}, // R6 stale reclaim
        '{1'b0, 5'd0,  7'd0,   1'b1, 5'd5,  7'd20, 5'd5,  1'b0, 7'd0,   4'd5}, // R5 match reclaim
        '{1'b1, 5'd31, 7'd127, 1'b0, 5'd0,  7'd0,  5'd31, 1'b1, 7'd127, 4'd3}, // R3 top entry
        '{1'b0, 5'd0,  7'd0,   1'b0, 5'd0,  7'd0,  5'd0,  1'b0, 7'd0,   4'd2}, // R2 miss
        '{1'b1, 5'd0,  7'd3,   1'b0, 5'd0,  7'd0,  5'd0,  1'b1, 7'd3,   4'd2}, // R2 hit
        '{1'b0, 5'd0,  7'd0,   1'b1, 5'd0,  7'd3,  5'd31, 1'b1, 7'd127, 4'd6}  // R6 other entry kept
    };

    task automatic idle();
        src_reg = '0; dst_en = '0; dst_reg = '0; dst_buf = '0;
        rcl_en = '0; rcl_reg = '0; rcl_buf = '0; flush = 1'b0;
    endtask

    task automatic chk(string req, logic gh, logic [BW-1:0] gb, logic eh, logic [BW-1:0] eb);
        n_run++;
        if (gh !== eh || (eh && gb !== eb) || (!eh && gb !== '0)) begin
            n_fail++;
            $display("FAIL %s: got hit=%0d buf=%0d, expected hit=%0d buf=%0d", req, gh, gb, eh, eb);
        end
    endtask

    // look a register up on lane 0, operand 0 (no bypass path there)
    task automatic look(string req, int r, logic eh, int eb);
        src_reg[0][0] = AW'(r);
        #1;
        chk(req, src_hit[0][0], src_buf[0][0], eh, BW'(eb));
    endtask

    task automatic step();
        @(posedge clk); #1; idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        // R1: all entries empty after reset
        for (int r = 0; r < NA; r++) look("R1", r, 1'b0, 0);

        // vector walk
        for (int v = 0; v < 8; v++) begin
            idle();
            dst_en[0] = VEC[v].wr; dst_reg[0] = VEC[v].wr_r; dst_buf[0] = VEC[v].wr_b;
            rcl_en[0] = VEC[v].rc; rcl_reg[0] = VEC[v].rc_r; rcl_buf[0] = VEC[v].rc_b;
            step();
            look($sformatf("R%0d vec%0d", VEC[v].req, v), VEC[v].lk_r, VEC[v].e_hit, VEC[v].e_buf);
        end
        look("R5 r0 cleared", 0, 1'b0, 0);

        // R4: lanes 1 and 3 write r7
        idle();
        dst_en = 4'b1010; dst_reg[1] = 5'd7; dst_buf[1] = 7'd40;
        dst_reg[3] = 5'd7; dst_buf[3] = 7'd41;
        step();
        look("R4", 7, 1'b1, 41);

        // R7/R8: lanes 0 and 2 write r9 in same group, sources read r9
        idle();
        dst_en = 4'b0101; dst_reg[0] = 5'd9; dst_buf[0] = 7'd50;
        dst_reg[2] = 5'd9; dst_buf[2] = 7'd51;
        src_reg[0][1] = 5'd9; src_reg[1][0] = 5'd9; src_reg[2][1] = 5'd9; src_reg[3][1] = 5'd9;
        #1;
        chk("R8 lane0 own dest", src_hit[0][1], src_buf[0][1], 1'b0, 0);
        chk("R7 lane1 sees lane0", src_hit[1][0], src_buf[1][0], 1'b1, 50);
        chk("R8 lane2 ignores own", src_hit[2][1], src_buf[2][1], 1'b1, 50);
        chk("R7 lane3 youngest", src_hit[3][1], src_buf[3][1], 1'b1, 51);
        step();
        look("R4 r9 stored", 9, 1'b1, 51);

        // R9: reclaim and rename of r12 in one cycle
        idle(); dst_en[0] = 1'b1; dst_reg[0] = 5'd12; dst_buf[0] = 7'd60; step();
        rcl_en[2] = 1'b1; rcl_reg[2] = 5'd12; rcl_buf[2] = 7'd60;
        dst_en[1] = 1'b1; dst_reg[1] = 5'd12; dst_buf[1] = 7'd61;
        step();
        look("R9", 12, 1'b1, 61);

        // R11: two reclaim ports in one cycle
        idle();
        dst_en = 4'b0011; dst_reg[0] = 5'd13; dst_buf[0] = 7'd70;
        dst_reg[1] = 5'd14; dst_buf[1] = 7'd71;
        step();
        rcl_en = 4'b1001; rcl_reg[0] = 5'd13; rcl_buf[0] = 7'd70;
        rcl_reg[3] = 5'd14; rcl_buf[3] = 7'd71;
        step();
        look("R11 port0", 13, 1'b0, 0);
        look("R11 port3", 14, 1'b0, 0);

        // R10: flush drops mappings and same-cycle writes
        idle(); dst_en[0] = 1'b1; dst_reg[0] = 5'd15; dst_buf[0] = 7'd80; step();
        flush = 1'b1; dst_en[2] = 1'b1; dst_reg[2] = 5'd16; dst_buf[2] = 7'd81;
        step();
        look("R10 old", 15, 1'b0, 0);
        look("R10 same-cycle write", 16, 1'b0, 0);
        look("R10 r31", 31, 1'b0, 0);

        // R1: reset in mid-run
        idle(); dst_en[0] = 1'b1; dst_reg[0] = 5'd5; dst_buf[0] = 7'd90; step();
        look("R3 before reset", 5, 1'b1, 90);
        rst = 1'b1; step(); rst = 1'b0;
        look("R1 mid-run", 5, 1'b0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule